// File: doc/BRIEF.md
# Exception and Interrupt Control Unit

This block sits next to a simple in-order processor pipeline and decides when normal program flow must be abandoned. It watches a synchronous exception request carrying a four-bit cause code, a set of external interrupt request lines, and a return-from-handler request. When an exception or an enabled interrupt is accepted, it does several things. It saves the interrupted program counter, records why control was taken, switches the processor to kernel mode with interrupts disabled, and asks the pipeline to fetch from the fixed handler address 0x80000080. On return it sends the pipeline back to the saved address and restores the earlier privilege and enable state.

The block holds three software-visible registers: the saved PC, a cause word and a status word. Kernel-mode software reads and writes them through a small select/read/write port. Interrupt requests are latched into a pending field, so a request that arrives while interrupts are off waits until software clears it. The status word keeps a three-level history of mode/enable pairs. Because of this history, one level of nested entry can be unwound correctly.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After synchronous reset the unit is in kernel mode, the redirect strobe is low, and the saved PC, cause word and status word all read as zero.
- R2: When `exc_valid_i` is high, `redirect_o` is high in that same cycle with `redirect_pc_o` = 0x80000080. From the next cycle the saved PC holds that cycle's `pc_i`, and cause bits 5:2 hold `exc_code_i`.
- R3: Status bits 5:0 hold three pairs {user-mode bit, enable bit}: current in 1:0, previous in 3:2, older in 5:4. A set bit 1 means user mode and a set bit 0 means interrupts are enabled. Entry shifts bits 3:0 up into 5:2 and clears 1:0. `kernel_o` is high exactly when status bit 1 is clear.
- R4: A return request (`rfe_i`) with no entry in the same cycle drives `redirect_o` high with `redirect_pc_o` equal to the saved PC. From the next cycle, status 3:0 take the old 5:2 and bits 5:4 keep their value.
- R5: A high level on interrupt line i sets cause bit 8+i one cycle later. The bit stays set, whatever the line does, until kernel software writes the cause word.
- R6: An interrupt is accepted when some pending bit and the matching status mask bit (status bits 15:8) are both set and the current enable bit is 1. The cause code recorded for it is 0.
- R7: With the enable bit clear, or with the matching mask bit clear, a pending interrupt is not accepted. Its pending bit is kept.
- R8: Priority is: synchronous exception first, then privilege violation, then interrupt. An accepted entry makes any return request and register write in the same cycle have no effect.
- R9: Any register read or write attempted in user mode is rejected with cause code 11 and handled as an entry. The write changes nothing, and the read data is zero.
- R10: In kernel mode, a read with select 0, 1 or 2 returns the saved PC, the cause word or the status word. A write with the same select sets the saved PC (all bits), the cause word (pending bits 15:8 and code bits 5:2) or the status word (mask bits 15:8 and pair bits 5:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_i | input | 32 | PC of the instruction in the stage that can take an exception |
| exc_valid_i | input | 1 | Synchronous exception request |
| exc_code_i | input | 4 | Cause code of the synchronous exception |
| irq_i | input | 8 | Interrupt request lines |
| rfe_i | input | 1 | Return-from-handler request |
| reg_rd_i | input | 1 | Register read request |
| reg_wr_i | input | 1 | Register write request |
| reg_sel_i | input | 2 | Register select: 0 saved PC, 1 cause, 2 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (zero when not a kernel read) |
| redirect_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | 32 | Fetch redirect target |
| kernel_o | output | 1 | High while in kernel mode |

## Verification
The assertions check several rules on every cycle:
- every entry lands in kernel mode and captures the PC;
- a return restores the previous pair and keeps the older one;
- a pending bit never drops without a cause write;
- a user-mode read never returns data.

Only the bench scenarios can show the rest: the numeric contents of the cause and status words after each event, the choice of winner when exception, interrupt and return arrive together, and the fact that a rejected user write leaves the status mask untouched.

// File: rtl/exc_pkg.sv
// Shared constants and types for the exception control unit.
// Assumes a 32-bit datapath and at most eight interrupt lines.
package exc_pkg;
    localparam logic [31:0] HANDLER_VEC = 32'h8000_0080;
    localparam logic [3:0]  CODE_IRQ    = 4'd0;
    localparam logic [3:0]  CODE_PRIV   = 4'd11;

    typedef enum logic [1:0] {
        SEL_EPC    = 2'd0,
        SEL_CAUSE  = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/exc_pending.sv
// Pending-interrupt latch: one sticky bit per request line.
// A bit is set by its line and is replaced only by a kernel write to cause.
module exc_pending #(
    parameter int NIRQ = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] irq_i,
    input  logic            wr_i,
    input  logic [NIRQ-1:0] wdata_i,
    output logic [NIRQ-1:0] pend_o
);
    genvar gi;
    generate
        for (gi = 0; gi < NIRQ; gi++) begin : g_line
            // Sticky bit for line gi, overwritten by software writes.
            always_ff @(posedge clk) begin
                if (!rst_n)    pend_o[gi] <= 1'b0;
                else if (wr_i) pend_o[gi] <= wdata_i[gi] | irq_i[gi];
                else           pend_o[gi] <= pend_o[gi] | irq_i[gi];
            end
        end
    endgenerate

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> ((pend_o & $past(pend_o)) == $past(pend_o))); // R5
endmodule

// File: rtl/exc_status.sv
// Status word: interrupt mask plus a three-level stack of {user, enable} pairs.
// Assumes push and pop are never high together (the top gives push priority).
module exc_status #(
    parameter int NIRQ = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_i,
    input  logic            pop_i,
    input  logic            wr_i,
    input  logic [NIRQ-1:0] mask_wdata_i,
    input  logic [5:0]      pairs_wdata_i,
    output logic [NIRQ-1:0] mask_o,
    output logic [5:0]      pairs_o
);
    // Pair stack: shift up on entry, down on return, load on write.
    always_ff @(posedge clk) begin
        if (!rst_n)      pairs_o <= 6'd0;
        else if (push_i) pairs_o <= {pairs_o[3:0], 2'b00};
        else if (pop_i)  pairs_o <= {pairs_o[5:4], pairs_o[5:2]};
        else if (wr_i)   pairs_o <= pairs_wdata_i;
    end

    // Mask register, changed only by software.
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_o <= '0;
        else if (wr_i) mask_o <= mask_wdata_i;
    end

    AST_PUSH_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (pairs_o[1:0] == 2'b00 && pairs_o[5:2] == $past(pairs_o[3:0]))); // R3
    AST_POP_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> (pairs_o[3:0] == $past(pairs_o[5:2]) && $stable(pairs_o[5:4]))); // R4
endmodule

// File: rtl/exc_ctrl_unit.sv
// Exception and interrupt control unit: picks one entry per cycle, saves the
// PC and cause, drives the fetch redirect and serves kernel register access.
// Assumes NIRQ <= 8 so the pending and mask fields fit in bits 15:8.
module exc_ctrl_unit #(
    parameter int NIRQ = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     pc_i,
    input  logic            exc_valid_i,
    input  logic [3:0]      exc_code_i,
    input  logic [NIRQ-1:0] irq_i,
    input  logic            rfe_i,
    input  logic            reg_rd_i,
    input  logic            reg_wr_i,
    input  logic [1:0]      reg_sel_i,
    input  logic [31:0]     reg_wdata_i,
    output logic [31:0]     reg_rdata_o,
    output logic            redirect_o,
    output logic [31:0]     redirect_pc_o,
    output logic            kernel_o
);
    import exc_pkg::*;

    localparam int FLD_LO = 8;

    logic [31:0]     epc_q;
    logic [3:0]      code_q;
    logic [NIRQ-1:0] pend;
    logic [NIRQ-1:0] mask;
    logic [5:0]      pairs;
    logic            take_priv, take_irq, entry, do_rfe, wr_ok, rd_ok;
    logic [3:0]      entry_code;
    logic            wr_cause, wr_status, wr_epc;
    logic [31:0]     cause_word, status_word;

    // Current mode comes from the user bit of the current pair.
    assign kernel_o = ~pairs[1];

    // Entry selection and priority: exception, privilege, interrupt.
    always_comb begin
        take_priv  = (reg_rd_i | reg_wr_i) & ~kernel_o;
        take_irq   = (|(pend & mask)) & pairs[0];
        entry      = exc_valid_i | take_priv | take_irq;
        if (exc_valid_i)    entry_code = exc_code_i;
        else if (take_priv) entry_code = CODE_PRIV;
        else                entry_code = CODE_IRQ;
        do_rfe    = rfe_i & ~entry;
        wr_ok     = reg_wr_i & kernel_o & ~entry;
        rd_ok     = reg_rd_i & kernel_o;
        wr_epc    = wr_ok && reg_sel_i == SEL_EPC;
        wr_cause  = wr_ok && reg_sel_i == SEL_CAUSE;
        wr_status = wr_ok && reg_sel_i == SEL_STATUS;
    end

    // Fetch redirect: handler vector on entry, saved PC on return.
    always_comb begin
        redirect_o    = entry | do_rfe;
        redirect_pc_o = entry ? HANDLER_VEC : (do_rfe ? epc_q : 32'd0);
    end

    // Saved PC: captured on entry, else loaded by software.
    always_ff @(posedge clk) begin
        if (!rst_n)      epc_q <= 32'd0;
        else if (entry)  epc_q <= pc_i;
        else if (wr_epc) epc_q <= reg_wdata_i;
    end

    // Cause code field: written on entry, else by software.
    always_ff @(posedge clk) begin
        if (!rst_n)        code_q <= 4'd0;
        else if (entry)    code_q <= entry_code;
        else if (wr_cause) code_q <= reg_wdata_i[5:2];
    end

    exc_pending #(.NIRQ(NIRQ)) pend_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_i   (irq_i),
        .wr_i    (wr_cause),
        .wdata_i (reg_wdata_i[FLD_LO +: NIRQ]),
        .pend_o  (pend)
    );

    exc_status #(.NIRQ(NIRQ)) stat_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .push_i        (entry),
        .pop_i         (do_rfe),
        .wr_i          (wr_status),
        .mask_wdata_i  (reg_wdata_i[FLD_LO +: NIRQ]),
        .pairs_wdata_i (reg_wdata_i[5:0]),
        .mask_o        (mask),
        .pairs_o       (pairs)
    );

    // Assemble the readable words from their fields.
    always_comb begin
        cause_word                = 32'd0;
        cause_word[FLD_LO +: NIRQ] = pend;
        cause_word[5:2]           = code_q;
        status_word                = 32'd0;
        status_word[FLD_LO +: NIRQ] = mask;
        status_word[5:0]           = pairs;
    end

    // Read mux, zero unless a kernel read.
    always_comb begin
        reg_rdata_o = 32'd0;
        if (rd_ok) begin
            case (reg_sel_i)
                SEL_EPC:    reg_rdata_o = epc_q;
                SEL_CAUSE:  reg_rdata_o = cause_word;
                SEL_STATUS: reg_rdata_o = status_word;
                default:    reg_rdata_o = 32'd0;
            endcase
        end
    end

    AST_ENTRY_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid_i || take_irq) |=> kernel_o); // R3
    AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_i |=> (epc_q == $past(pc_i) && code_q == $past(exc_code_i))); // R2
    AST_USER_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !kernel_o |-> reg_rdata_o == 32'd0); // R9
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!pairs[0] && !exc_valid_i && !take_priv) |-> !(redirect_o && redirect_pc_o == HANDLER_VEC)); // R7
endmodule

// File: tb/exc_ctrl_unit_tb_top.sv
`timescale 1ns/1ps
module exc_ctrl_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = 32'd0;
    logic        exc_valid_i = 1'b0;
    logic [3:0]  exc_code_i = 4'd0;
    logic [7:0]  irq_i = 8'd0;
    logic        rfe_i = 1'b0;
    logic        reg_rd_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [1:0]  reg_sel_i = 2'd0;
    logic [31:0] reg_wdata_i = 32'd0;
    logic [31:0] reg_rdata_o;
    logic        redirect_o;
    logic [31:0] redirect_pc_o;
    logic        kernel_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic [31:0] val;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    exc_ctrl_unit dut_i (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .exc_valid_i(exc_valid_i),
        .exc_code_i(exc_code_i), .irq_i(irq_i), .rfe_i(rfe_i),
        .reg_rd_i(reg_rd_i), .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o), .kernel_o(kernel_o)
    );

    // Driver side: queue an expected value.
    task automatic expect_val(input string tag, input logic [31:0] v);
        exp_t e;
        e.tag = tag;
        e.val = v;
        sb_q.push_back(e);
    endtask

    // Monitor side: pop the oldest expectation and compare.
    task automatic observe(input logic [31:0] act);
        exp_t e;
        checks++;
        if (sb_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard empty act=%h", act);
        end else begin
            e = sb_q.pop_front();
            if (act !== e.val) begin
                errors++;
                $display("FAIL %s act=%h exp=%h", e.tag, act, e.val);
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] v);
        reg_rd_i = 1'b1;
        reg_sel_i = sel;
        #2 v = reg_rdata_o;
        tick();
        reg_rd_i = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        reg_wr_i = 1'b1;
        reg_sel_i = sel;
        reg_wdata_i = d;
        tick();
        reg_wr_i = 1'b0;
    endtask

    task automatic chk_reg(input string tag, input logic [1:0] sel, input logic [31:0] v);
        logic [31:0] r;
        expect_val(tag, v);
        rd(sel, r);
        observe(r);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1 reset state
        expect_val("R1 kernel", 32'd1);  observe({31'd0, kernel_o});
        expect_val("R1 redirect", 32'd0); observe({31'd0, redirect_o});
        chk_reg("R1 epc", 2'd0, 32'd0);
        chk_reg("R1 cause", 2'd1, 32'd0);
        chk_reg("R1 status", 2'd2, 32'd0);

        // R10 write status: mask FF, pairs 00_01_11 (user, enabled)
        wr(2'd2, 32'h0000_FF07);
        #2 expect_val("R10 user after write", 32'd0); observe({31'd0, kernel_o});

        // R2 synchronous exception
        pc_i = 32'h0040_0100; exc_valid_i = 1'b1; exc_code_i = 4'd12;
        #2 expect_val("R2 redirect", 32'd1); observe({31'd0, redirect_o});
        expect_val("R2 vector", 32'h8000_0080); observe(redirect_pc_o);
        tick(); exc_valid_i = 1'b0;
        expect_val("R3 kernel after entry", 32'd1); observe({31'd0, kernel_o});
        chk_reg("R2 epc", 2'd0, 32'h0040_0100);
        chk_reg("R2 cause code", 2'd1, 32'h0000_0030);
        chk_reg("R3 status push", 2'd2, 32'h0000_FF1C);

        // R4 return
        rfe_i = 1'b1;
        #2 expect_val("R4 redirect", 32'd1); observe({31'd0, redirect_o});
        expect_val("R4 target", 32'h0040_0100); observe(redirect_pc_o);
        tick(); rfe_i = 1'b0;
        expect_val("R4 user restored", 32'd0); observe({31'd0, kernel_o});

        // R9 user-mode access: read and write together, write of zero
        pc_i = 32'h0040_0200;
        reg_rd_i = 1'b1; reg_wr_i = 1'b1; reg_sel_i = 2'd2; reg_wdata_i = 32'd0;
        #2 expect_val("R9 no data", 32'd0); observe(reg_rdata_o);
        expect_val("R9 vector", 32'h8000_0080); observe(redirect_pc_o);
        tick(); reg_rd_i = 1'b0; reg_wr_i = 1'b0;
        chk_reg("R9 cause code 11", 2'd1, 32'h0000_002C);
        chk_reg("R9 write ignored, pop then push", 2'd2, 32'h0000_FF1C);

        // R5 / R7: interrupt while disabled is latched, not taken
        irq_i = 8'h08;
        tick(); irq_i = 8'h00;
        #2 expect_val("R7 not taken", 32'd0); observe({31'd0, redirect_o});
        tick(); tick();
        chk_reg("R5 pending kept", 2'd1, 32'h0000_082C);

        // R6 enable: interrupt taken the cycle after the write
        wr(2'd2, 32'h0000_FF01);
        pc_i = 32'h0000_0500;
        #2 expect_val("R6 redirect", 32'd1); observe({31'd0, redirect_o});
        expect_val("R6 vector", 32'h8000_0080); observe(redirect_pc_o);
        tick();
        chk_reg("R6 cause code 0", 2'd1, 32'h0000_0800);
        chk_reg("R6 epc", 2'd0, 32'h0000_0500);
        chk_reg("R6 status push", 2'd2, 32'h0000_FF04);

        // R7 masked line: enabled but mask clear
        wr(2'd1, 32'd0);
        wr(2'd2, 32'h0000_0001);
        irq_i = 8'h20;
        tick(); irq_i = 8'h00;
        #2 expect_val("R7 masked not taken", 32'd0); observe({31'd0, redirect_o});
        tick();
        chk_reg("R7 masked pending kept", 2'd1, 32'h0000_2000);

        // R8 exception beats interrupt; return in same cycle ignored
        wr(2'd2, 32'h0000_FF01);
        pc_i = 32'h0000_0600; exc_valid_i = 1'b1; exc_code_i = 4'd8; rfe_i = 1'b1;
        #2 expect_val("R8 vector wins", 32'h8000_0080); observe(redirect_pc_o);
        tick(); exc_valid_i = 1'b0; rfe_i = 1'b0;
        chk_reg("R8 cause code 8", 2'd1, 32'h0000_2020);
        chk_reg("R8 epc", 2'd0, 32'h0000_0600);
        chk_reg("R8 rfe ignored", 2'd2, 32'h0000_FF04);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule